// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal valid/ready request bus and an external asynchronous static RAM organised as 16-bit words with a 19-bit word address. Each accepted request becomes exactly one RAM cycle. A read drives output enable and returns the word with a one-cycle valid pulse. A write drives a write-enable pulse while the block's own data drivers are on. A 2-bit byte mask picks the lower lane, the upper lane or both.

Every timing minimum of the RAM is a nanosecond parameter, alongside a clock-period parameter. Each minimum is rounded up to whole clock cycles, and each phase of the cycle is held for at least that count. The data bus is split into an outgoing value, a driver enable and an incoming value, so the pad tristate can sit outside the block. The drivers are switched on only after output enable has been high for the output-disable time, which rules out contention with the RAM.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and between cycles the RAM is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_lb_n`=`mem_ub_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: `req_ready` is high only while no RAM cycle is in progress, so it is never high while the RAM is selected. A request is taken on a clock edge with `req_valid` and `req_ready` both high.
- R3: A read selects the RAM with `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD cycles, where RD is the largest of the rounded access, read-cycle and output-enable times (11 with the bench values). The bus is sampled at the last of those edges. `rsp_valid` is then high for exactly one cycle, the first cycle after `mem_oe_n` returns high.
- R4: Mask bit 0 selects the lower lane (`dq[7:0]`, enable `mem_lb_n`) and bit 1 selects the upper lane (`dq[15:8]`, enable `mem_ub_n`). Both enables are active low. A mask of 00 means the full word. On a read, unselected lanes return zero in `rsp_rdata`. On a write, unselected lanes of the addressed word keep their stored contents.
- R5: A write holds `mem_we_n` low for exactly WP cycles, the largest of the rounded write-pulse, data-setup, address-to-end and select-to-end times (9 with the bench values). Output enable stays high for the whole write.
- R6: During a write, `mem_dq_oe` is high for at least one cycle before `mem_we_n` falls and for at least one cycle after it rises. `mem_dq_o` does not change while the drivers are on.
- R7: `mem_dq_oe` rises no earlier than OHZ full cycles after `mem_oe_n` rose, where OHZ is the rounded output-disable time (4 with the bench values). A write that directly follows a read is delayed as needed to meet this.
- R8: A write begun with the bus already quiet keeps the RAM selected for 1 + WP + REC cycles, where REC = max(1, WC − 1 − WP) and WC is the rounded write-cycle time (13 cycles in total with the bench values).
- R9: `mem_addr`, `mem_lb_n` and `mem_ub_n` do not change while the RAM stays selected.
- R10: Each nanosecond value that is not a whole multiple of the clock period is rounded up to the next whole cycle count, never down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 19 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane mask (bit 0 lower, bit 1 upper; 00 = both) |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | RAM address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data read from the RAM |

## Verification
The bench builds the block with a 5 ns clock period. It uses an access time of 52 ns, a read cycle of 48 ns, an output-disable time of 17 ns, an address-to-end time of 43 ns and a write cycle of 62 ns. The other values are the fast-grade figures. Because the access time is not a multiple of the period, rounding it down would shorten the read by one cycle, and the bench's RAM model only supplies valid data after the full count. The long write cycle forces a recovery phase of three cycles instead of the one-cycle floor. A read followed at once by a write brings the output-disable turnaround into play.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WSETUP = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WRECOV = 3'd4
  } phase_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Output enable low time: covers access, read cycle and OE-to-data.
  function automatic int read_cycles(input int aa_ns, input int rc_ns,
                                     input int oe_ns, input int clk_ns);
    return max_of(max_of(ns_to_cycles(aa_ns, clk_ns), ns_to_cycles(rc_ns, clk_ns)),
                  ns_to_cycles(oe_ns, clk_ns));
  endfunction

  // Write enable low time: pulse width, data setup, address and select to end.
  function automatic int pulse_cycles(input int wp_ns, input int dw_ns, input int aw_ns,
                                      input int cw_ns, input int clk_ns);
    return max_of(max_of(ns_to_cycles(wp_ns, clk_ns), ns_to_cycles(dw_ns, clk_ns)),
                  max_of(ns_to_cycles(aw_ns, clk_ns), ns_to_cycles(cw_ns, clk_ns)));
  endfunction

  // Recovery after write enable rises, padding the cycle out to its minimum.
  function automatic int recov_cycles(input int wc_ns, input int pulse, input int clk_ns);
    return max_of(1, ns_to_cycles(wc_ns, clk_ns) - 1 - pulse);
  endfunction

  function automatic int width_for(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (count != {CNT_W{1'b1}}) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctl_turn.sv
`timescale 1ns/1ps
module sram_ctl_turn #(
  parameter int QUIET_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic quiet
);

  localparam int QW = (QUIET_CYC < 1) ? 1 : $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] QLIM = QW'(QUIET_CYC);

  logic [QW-1:0] hi_cnt;

  // Counts cycles with output enable high, saturating at the turnaround time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!oe_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt < QLIM) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign quiet = (hi_cnt >= QLIM);

endmodule

// File: rtl/sram_ctl_lanes.sv
`timescale 1ns/1ps
module sram_ctl_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES-1:0]        held_lanes,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES-1:0]        req_lanes,
  output logic [LANES*LANE_W-1:0] rd_merged
);

  // An empty mask means the whole word.
  assign req_lanes = (req_mask == '0) ? {LANES{1'b1}} : req_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_merged[g*LANE_W +: LANE_W] =
      held_lanes[g] ? bus_in[g*LANE_W +: LANE_W] : {LANE_W{1'b0}};
  end

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int RD_CYC    = 11,
  parameter int PULSE_CYC = 9,
  parameter int RECOV_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [CNT_W-1:0] count,
  input  logic             quiet,
  output phase_e           phase,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             cnt_clr
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LAST = CNT_W'(RECOV_CYC - 1);

  phase_e nxt;

  assign ready = (phase == PH_IDLE);

  always_comb begin
    nxt     = phase;
    cnt_clr = 1'b0;
    capture = 1'b0;
    accept  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        cnt_clr = 1'b1;
        if (req_valid) begin
          accept = 1'b1;
          nxt    = req_we ? PH_WSETUP : PH_READ;
        end
      end
      PH_READ: begin
        if (count == RD_LAST) begin
          capture = 1'b1;
          cnt_clr = 1'b1;
          nxt     = PH_IDLE;
        end
      end
      PH_WSETUP: begin
        if (quiet) begin
          cnt_clr = 1'b1;
          nxt     = PH_WPULSE;
        end
      end
      PH_WPULSE: begin
        if (count == WP_LAST) begin
          cnt_clr = 1'b1;
          nxt     = PH_WRECOV;
        end
      end
      PH_WRECOV: begin
        if (count == RC_LAST) begin
          cnt_clr = 1'b1;
          nxt     = PH_IDLE;
        end
      end
      default: begin
        cnt_clr = 1'b1;
        nxt     = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_OHZ_NS  = 20,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_DW_NS   = 25,
  parameter int T_AW_NS   = 45,
  parameter int T_CW_NS   = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANES     = 2;
  localparam int LANE_W    = DATA_W / LANES;
  localparam int RD_CYC    = read_cycles(T_AA_NS, T_RC_NS, T_OE_NS, CLK_NS);
  localparam int PULSE_CYC = pulse_cycles(T_WP_NS, T_DW_NS, T_AW_NS, T_CW_NS, CLK_NS);
  localparam int RECOV_CYC = recov_cycles(T_WC_NS, PULSE_CYC, CLK_NS);
  localparam int OHZ_CYC   = ns_to_cycles(T_OHZ_NS, CLK_NS);
  localparam int MAX_CYC   = max_of(max_of(RD_CYC, PULSE_CYC), RECOV_CYC);
  localparam int CNT_W     = width_for(MAX_CYC);

  phase_e            phase;
  logic [CNT_W-1:0]  count;
  logic              cnt_clr;
  logic              evt_accept;
  logic              evt_capture;
  logic              bus_quiet;
  logic              selected;
  logic              wr_phase;
  logic [LANES-1:0]  req_lanes;
  logic [LANES-1:0]  lanes_q;
  logic [DATA_W-1:0] rd_merged;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  sram_ctl_fsm #(
    .CNT_W     (CNT_W),
    .RD_CYC    (RD_CYC),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .count     (count),
    .quiet     (bus_quiet),
    .phase     (phase),
    .ready     (req_ready),
    .accept    (evt_accept),
    .capture   (evt_capture),
    .cnt_clr   (cnt_clr)
  );

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .count (count)
  );

  sram_ctl_turn #(
    .QUIET_CYC (OHZ_CYC)
  ) u_turn (
    .clk   (clk),
    .rst_n (rst_n),
    .oe_n  (mem_oe_n),
    .quiet (bus_quiet)
  );

  sram_ctl_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .req_mask   (req_be),
    .held_lanes (lanes_q),
    .bus_in     (mem_dq_i),
    .req_lanes  (req_lanes),
    .rd_merged  (rd_merged)
  );

  // Request registers: held for the whole RAM cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
    end else if (evt_accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      lanes_q <= req_lanes;
    end
  end

  // Response registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= evt_capture;
      if (evt_capture) rdata_q <= rd_merged;
    end
  end

  assign selected  = (phase != PH_IDLE);
  assign wr_phase  = (phase == PH_WSETUP) || (phase == PH_WPULSE) || (phase == PH_WRECOV);

  assign mem_addr  = addr_q;
  assign mem_cs1_n = ~selected;
  assign mem_cs2   = selected;
  assign mem_oe_n  = ~(phase == PH_READ);
  assign mem_we_n  = ~(phase == PH_WPULSE);
  assign mem_lb_n  = ~(selected && lanes_q[0]);
  assign mem_ub_n  = ~(selected && lanes_q[1]);
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = wr_phase && bus_quiet;

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              evt_capture
);

  assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2));

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_follows_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (rsp_valid && mem_oe_n));

  assert_write_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs1_n && mem_cs2 && mem_dq_oe));

  assert_drive_before_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_drive_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |->
      ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_addr    (mem_addr),
  .mem_cs1_n   (mem_cs1_n),
  .mem_cs2     (mem_cs2),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_lb_n    (mem_lb_n),
  .mem_ub_n    (mem_ub_n),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe   (mem_dq_oe),
  .evt_capture (evt_capture)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  localparam int CLK  = 5;
  localparam int P_RC = 48;
  localparam int P_AA = 52;
  localparam int P_OE = 25;
  localparam int P_OHZ = 17;
  localparam int P_WC = 62;
  localparam int P_WP = 40;
  localparam int P_DW = 25;
  localparam int P_AW = 43;
  localparam int P_CW = 45;

  // Expected cycle counts, rounded up from the requirements.
  function automatic int up(input int ns);
    int q;
    q = ns / CLK;
    if ((ns % CLK) != 0) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction
  function automatic int big(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  localparam int E_AA  = up(P_AA);
  localparam int E_RD  = big(big(up(P_AA), up(P_RC)), up(P_OE));
  localparam int E_WP  = big(big(up(P_WP), up(P_DW)), big(up(P_AW), up(P_CW)));
  localparam int E_REC = big(1, up(P_WC) - 1 - E_WP);
  localparam int E_OHZ = up(P_OHZ);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i = 16'hEEEE;

  always #2.5 clk = ~clk;

  sram_ctl #(
    .CLK_NS (CLK), .T_RC_NS (P_RC), .T_AA_NS (P_AA), .T_OE_NS (P_OE),
    .T_OHZ_NS (P_OHZ), .T_WC_NS (P_WC), .T_WP_NS (P_WP), .T_DW_NS (P_DW),
    .T_AW_NS (P_AW), .T_CW_NS (P_CW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_we (req_we), .req_wdata (req_wdata), .req_be (req_be),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .mem_addr (mem_addr),
    .mem_cs1_n (mem_cs1_n), .mem_cs2 (mem_cs2), .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n), .mem_lb_n (mem_lb_n), .mem_ub_n (mem_ub_n),
    .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // RAM model and port monitor, all at the falling edge.
  logic [15:0] sram [0:255];
  int sel_run = 0, oe_run = 0, we_run = 0, pre_run = 0, post_run = 0;
  int last_sel = 0, last_oe = 0, last_we = 0, last_pre = 0, last_post = 0;
  int oe_hi = 0, oe_k = 0, rsp_cnt = 0;
  int bad_turn = 0, bad_hold = 0, bad_wdata = 0, bad_ready = 0, bad_rsp = 0, bad_undriven = 0;
  bit seen_we = 0;
  logic [15:0] last_rsp = '0;
  logic [15:0] wl_d = '0;
  logic        wl_lb = 1'b1, wl_ub = 1'b1;
  logic [7:0]  wl_a = '0;
  logic        p_sel = 1'b0, p_oe_n = 1'b1, p_dq_oe = 1'b0, p_rsp = 1'b0, p_lb = 1'b1, p_ub = 1'b1;
  logic [18:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  always @(negedge clk) begin
    logic sel_now;
    logic [15:0] drv;
    sel_now = !mem_cs1_n && mem_cs2;
    if (!mem_oe_n) oe_hi = 0; else if (oe_hi < 1000) oe_hi++;
    if (mem_dq_oe && oe_hi <= E_OHZ) bad_turn++;
    if (sel_now && p_sel &&
        (mem_addr !== p_addr || mem_lb_n !== p_lb || mem_ub_n !== p_ub)) bad_hold++;
    if (mem_dq_oe && p_dq_oe && mem_dq_o !== p_dq) bad_wdata++;
    if (req_ready && sel_now) bad_ready++;
    if (sel_now && !p_sel) begin
      sel_run = 0; pre_run = 0; post_run = 0; seen_we = 0;
    end
    if (sel_now) sel_run++;
    else if (p_sel) last_sel = sel_run;
    if (sel_now && !mem_oe_n) oe_run++;
    else begin
      if (oe_run != 0) last_oe = oe_run;
      oe_run = 0;
    end
    if (!mem_we_n) begin
      we_run++; seen_we = 1;
      wl_d = mem_dq_o; wl_lb = mem_lb_n; wl_ub = mem_ub_n; wl_a = mem_addr[7:0];
      if (!mem_dq_oe) bad_undriven++;
    end else if (we_run != 0) begin
      last_we = we_run; we_run = 0;
      if (!wl_lb) sram[wl_a][7:0]  = wl_d[7:0];
      if (!wl_ub) sram[wl_a][15:8] = wl_d[15:8];
    end
    if (sel_now && mem_we_n && mem_dq_oe) begin
      if (!seen_we) pre_run++; else post_run++;
    end
    if (!sel_now && p_sel) begin
      last_pre = pre_run; last_post = post_run;
    end
    if (rsp_valid) begin
      rsp_cnt++; last_rsp = rsp_rdata;
      if (p_rsp) bad_rsp++;
      if (!(!p_oe_n && mem_oe_n)) bad_rsp++;
    end
    if (sel_now && !mem_oe_n && mem_we_n) begin
      oe_k++;
      drv[7:0]  = mem_lb_n ? 8'hEE : ((oe_k >= E_AA) ? sram[mem_addr[7:0]][7:0]  : 8'hC3);
      drv[15:8] = mem_ub_n ? 8'hEE : ((oe_k >= E_AA) ? sram[mem_addr[7:0]][15:8] : 8'hC3);
    end else begin
      oe_k = 0;
      drv = 16'hEEEE;
    end
    mem_dq_i = drv;
    p_sel = sel_now; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_rsp = rsp_valid;
    p_lb = mem_lb_n; p_ub = mem_ub_n; p_addr = mem_addr; p_dq = mem_dq_o;
  end

  task automatic issue(input logic [18:0] a, input logic w, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d; req_be = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 cs1_n", mem_cs1_n, 1'b1);
    check("R1 cs2", mem_cs2, 1'b0);
    check("R1 oe_n/we_n", {mem_oe_n, mem_we_n}, 2'b11);
    check("R1 lb_n/ub_n", {mem_lb_n, mem_ub_n}, 2'b11);
    check("R1 dq_oe", mem_dq_oe, 1'b0);
    check("R1 ready", req_ready, 1'b1);
    check("R1 rsp_valid", rsp_valid, 1'b0);
  endtask

  task automatic t_word;
    int n;
    issue(19'h12345, 1'b1, 16'h1234, 2'b11);
    check("R5 we low cycles", last_we, E_WP);
    check("R10 pulse rounded up", last_we, 9);
    check("R8 write select cycles", last_sel, 1 + E_WP + E_REC);
    check("R6 drive before we", last_pre >= 1, 1'b1);
    check("R6 drive after we", last_post >= 1, 1'b1);
    check("R1 idle after write", {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);
    n = rsp_cnt;
    issue(19'h12345, 1'b0, 16'h0, 2'b11);
    check("R3 oe low cycles", last_oe, E_RD);
    check("R10 access rounded up", last_oe, 11);
    check("R3 one response", rsp_cnt - n, 1);
    check("R3 read data", last_rsp, 16'h1234);
  endtask

  task automatic t_bytes;
    issue(19'h12345, 1'b1, 16'hAB99, 2'b10);
    issue(19'h12345, 1'b0, 16'h0, 2'b11);
    check("R4 upper write keeps lower", last_rsp, 16'hAB34);
    issue(19'h12345, 1'b1, 16'h77CD, 2'b01);
    issue(19'h12345, 1'b0, 16'h0, 2'b11);
    check("R4 lower write keeps upper", last_rsp, 16'hABCD);
    issue(19'h12345, 1'b0, 16'h0, 2'b01);
    check("R4 lower read zeroes upper", last_rsp, 16'h00CD);
    issue(19'h12345, 1'b0, 16'h0, 2'b10);
    check("R4 upper read zeroes lower", last_rsp, 16'hAB00);
  endtask

  task automatic t_mask0;
    issue(19'h00A10, 1'b1, 16'h5A5A, 2'b00);
    issue(19'h00A10, 1'b0, 16'h0, 2'b11);
    check("R4 empty-mask write is full word", last_rsp, 16'h5A5A);
    issue(19'h00A10, 1'b0, 16'h0, 2'b00);
    check("R4 empty-mask read is full word", last_rsp, 16'h5A5A);
  endtask

  task automatic t_turn;
    issue(19'h00B20, 1'b1, 16'h1111, 2'b11);
    issue(19'h00B20, 1'b0, 16'h0, 2'b11);
    check("R3 read before turnaround", last_rsp, 16'h1111);
    issue(19'h00B20, 1'b1, 16'h2222, 2'b11);
    check("R7 no early drive after read", bad_turn, 0);
    check("R6 drive before delayed we", last_pre >= 1, 1'b1);
    issue(19'h00B20, 1'b0, 16'h0, 2'b11);
    check("R7 write after read stored", last_rsp, 16'h2222);
  endtask

  task automatic t_b2b;
    issue(19'h12345, 1'b0, 16'h0, 2'b11);
    check("R3 back-to-back read 1", last_rsp, 16'hABCD);
    issue(19'h00A10, 1'b0, 16'h0, 2'b11);
    check("R3 back-to-back read 2", last_rsp, 16'h5A5A);
  endtask

  task automatic t_final;
    check("R2 ready while selected", bad_ready, 0);
    check("R3 response pulse/timing", bad_rsp, 0);
    check("R6 write data stable", bad_wdata, 0);
    check("R6 undriven during we", bad_undriven, 0);
    check("R7 turnaround overall", bad_turn, 0);
    check("R9 address/lanes held", bad_hold, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sram[i] = 16'h0000;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset;
    t_word;
    t_bytes;
    t_mask0;
    t_turn;
    t_b2b;
    t_final;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule